// File: doc/BRIEF.md
# Fully associative translation lookaside buffer with variable page size

This block holds a parameterised set of address translation entries and compares a virtual address against all of them in the same cycle. Each entry maps a page of 1 KB, 4 KB, 64 KB or 1 MB. It may be tagged with an address-space identifier, or marked shared so that it serves every address space. The lookup is purely combinational. It returns a single-hit flag, a separate multiple-hit flag, the index of the matching entry, that entry's fields, and the translated physical address.

Entries are loaded one at a time through a write port, either at an explicit index or at the slot chosen by a replacement counter. The counter advances by one on each access strobe. It wraps at a programmable bound or at the last entry. A global invalidate clears every entry in one clock.

Top module: `tlb_assoc_lookup`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits or multi-hits, and the replacement counter reads 0.
- R2: An entry whose valid bit is clear never takes part in a match, even when its other fields fit the address.
- R3: The ASID comparison is active unless `sv_mode` and `priv_mode` are both 1. When it is active, a non-shared entry matches only if its stored ASID equals `lk_asid`. A shared entry skips the comparison in every case.
- R4: The size code selects the page: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The page base is `vpn` shifted left by 10 with the low log2(page size) bits cleared. An address matches from the base through base + size - 1 inclusive. `lk_paddr` is the PPN shifted left by 10, with the same low bits cleared, ORed with the address's offset inside the page.
- R5: When two or more entries match, `lk_multi` is 1 and `lk_hit` is 0.
- R6: When exactly one entry matches, `lk_hit` is 1 and `lk_idx`, `lk_ppn`, `lk_size`, `lk_prot`, `lk_cache` and `lk_dirty` report that entry. Without a single hit, all of these outputs and `lk_paddr` are 0.
- R7: Each cycle with `acc_step` high advances the replacement counter by one. Without `acc_step` the counter holds its value.
- R8: An advance yields 0 instead of the incremented value in two cases: `bound` is nonzero and the incremented value is greater than `bound`, or the incremented value is greater than N_ENTRIES - 1.
- R9: `inval_all` clears every valid bit at the next clock edge. It takes priority over a write in the same cycle, and that write is discarded.
- R10: A write stores all fields at `wr_idx` when `wr_use_ctr` is 0. When `wr_use_ctr` is 1, it stores them at the counter value held before that clock edge. The new contents are visible to lookups from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inval_all | input | 1 | Clear every valid bit |
| wr_en | input | 1 | Load one entry |
| wr_use_ctr | input | 1 | 1: write slot from counter, 0: from wr_idx |
| wr_idx | input | IDX_W | Explicit write slot |
| wr_valid | input | 1 | Valid bit to store |
| wr_shared | input | 1 | Shared bit to store |
| wr_asid | input | 8 | ASID to store |
| wr_vpn | input | 22 | Virtual page number to store |
| wr_ppn | input | 19 | Physical page number to store |
| wr_size | input | 2 | Page size code to store |
| wr_prot | input | 2 | Protection field to store |
| wr_cache | input | 1 | Cacheable bit to store |
| wr_dirty | input | 1 | Dirty bit to store |
| lk_vaddr | input | 32 | Virtual address to look up |
| lk_asid | input | 8 | Current address-space identifier |
| sv_mode | input | 1 | Single virtual space mode |
| priv_mode | input | 1 | Processor in privileged mode |
| acc_step | input | 1 | Access strobe that advances the counter |
| bound | input | 6 | Counter wrap bound, 0 means none |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_multi | output | 1 | Two or more entries matched |
| lk_idx | output | IDX_W | Index of the matching entry |
| lk_ppn | output | 19 | PPN of the matching entry |
| lk_size | output | 2 | Size code of the matching entry |
| lk_prot | output | 2 | Protection field of the matching entry |
| lk_cache | output | 1 | Cacheable bit of the matching entry |
| lk_dirty | output | 1 | Dirty bit of the matching entry |
| lk_paddr | output | 29 | Translated physical address |
| repl_ctr | output | 6 | Replacement counter |

## Verification
The storage can only be observed through combinational lookups, so a corrupted valid bit, tag or size code appears at the ports in the first cycle after the bad write. It shows as a wrong hit, a wrong multi-hit, a wrong index or a wrong physical address. A lookup at the first byte, the last byte and the byte just past each page size catches a size mask that is off by one code. A counter that wraps at the wrong point diverges from the expected value at the strobe where the wrap should occur. That error then spreads to every later write made through the counter.

// File: rtl/tlb_assoc_pkg.sv
package tlb_assoc_pkg;
   localparam int VA_W     = 32;
   localparam int VPN_W    = 22;
   localparam int PPN_W    = 19;
   localparam int ASID_W   = 8;
   localparam int PG_SHIFT = 10;
   localparam int PA_W     = PPN_W + PG_SHIFT;

   typedef struct packed {
      logic              valid;
      logic              shared;
      logic [ASID_W-1:0] asid;
      logic [VPN_W-1:0]  vpn;
      logic [PPN_W-1:0]  ppn;
      logic [1:0]        size;
      logic [1:0]        prot;
      logic              cache;
      logic              dirty;
   } tlb_ent_t;

   // page-number bits that take part in the compare for each size code
   function automatic logic [VPN_W-1:0] pg_keep(input logic [1:0] sz);
      logic [VPN_W-1:0] k;
      case (sz)
         2'd0:    k = '1;
         2'd1:    k = ~VPN_W'(22'h3);
         2'd2:    k = ~VPN_W'(22'h3F);
         default: k = ~VPN_W'(22'h3FF);
      endcase
      return k;
   endfunction
endpackage

// File: rtl/tlb_ent_cmp.sv
module tlb_ent_cmp
   import tlb_assoc_pkg::*;
(
   input  tlb_ent_t          ent,
   input  logic [VPN_W-1:0]  va_pn,
   input  logic [ASID_W-1:0] asid,
   input  logic              use_asid,
   output logic              match
);
   logic asid_ok;
   logic page_ok;

   always_comb begin
      asid_ok = !use_asid || ent.shared || (ent.asid == asid);
      page_ok = ((va_pn ^ ent.vpn) & pg_keep(ent.size)) == '0;
      match   = ent.valid && asid_ok && page_ok;
   end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
   parameter int N_ENTRIES = 64,
   parameter int CTR_W     = 6,
   parameter bit ENABLE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [CTR_W-1:0] bound,
   output logic [CTR_W-1:0] ctr
);
   localparam logic [CTR_W:0] LAST = (CTR_W+1)'(N_ENTRIES - 1);

   generate
      if (ENABLE) begin : g_ctr
         logic [CTR_W-1:0] ctr_q;
         logic [CTR_W:0]   nxt;
         logic             wrap;

         always_comb begin
            nxt  = {1'b0, ctr_q} + (CTR_W+1)'(1);
            wrap = ((bound != '0) && (nxt > {1'b0, bound})) || (nxt > LAST);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ctr_q <= '0;
            else if (step) ctr_q <= wrap ? '0 : nxt[CTR_W-1:0];
         end

         assign ctr = ctr_q;
      end else begin : g_none
         assign ctr = '0;
      end
   endgenerate
endmodule

// File: rtl/tlb_sel_or.sv
module tlb_sel_or
   import tlb_assoc_pkg::*;
#(
   parameter int N_ENTRIES = 64,
   parameter int IDX_W     = 6
) (
   input  logic [N_ENTRIES-1:0] match,
   input  tlb_ent_t             ents [N_ENTRIES],
   output logic                 one,
   output logic                 many,
   output logic [IDX_W-1:0]     idx,
   output tlb_ent_t             sel
);
   logic seen;

   always_comb begin
      seen = 1'b0;
      many = 1'b0;
      idx  = '0;
      sel  = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (match[i]) begin
            many = many | seen;
            seen = 1'b1;
            idx  = idx | IDX_W'(i);
            sel  = sel | ents[i];
         end
      end
      one = seen & ~many;
   end
endmodule

// File: rtl/tlb_assoc_lookup.sv
module tlb_assoc_lookup
   import tlb_assoc_pkg::*;
#(
   parameter int N_ENTRIES = 64,
   parameter int CTR_W     = 6,
   parameter bit HAS_REPL  = 1'b1,
   localparam int IDX_W    = $clog2(N_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval_all,
   input  logic              wr_en,
   input  logic              wr_use_ctr,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_shared,
   input  logic [7:0]        wr_asid,
   input  logic [21:0]       wr_vpn,
   input  logic [18:0]       wr_ppn,
   input  logic [1:0]        wr_size,
   input  logic [1:0]        wr_prot,
   input  logic              wr_cache,
   input  logic              wr_dirty,
   input  logic [31:0]       lk_vaddr,
   input  logic [7:0]        lk_asid,
   input  logic              sv_mode,
   input  logic              priv_mode,
   input  logic              acc_step,
   input  logic [5:0]        bound,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [IDX_W-1:0]  lk_idx,
   output logic [18:0]       lk_ppn,
   output logic [1:0]        lk_size,
   output logic [1:0]        lk_prot,
   output logic              lk_cache,
   output logic              lk_dirty,
   output logic [28:0]       lk_paddr,
   output logic [5:0]        repl_ctr
);
   generate
      if (N_ENTRIES < 2 || N_ENTRIES > (1 << CTR_W))
         $error("tlb_assoc_lookup: N_ENTRIES must lie in 2 .. 2**CTR_W");
      if (CTR_W != 6)
         $error("tlb_assoc_lookup: counter port is six bits wide");
      if ((1 << IDX_W) != N_ENTRIES)
         $error("tlb_assoc_lookup: N_ENTRIES must be a power of two");
   endgenerate

   tlb_ent_t            ent_q [N_ENTRIES];
   logic [N_ENTRIES-1:0] match;
   logic                use_asid;
   logic [IDX_W-1:0]    wr_ptr;
   tlb_ent_t            wr_ent;
   tlb_ent_t            sel;
   logic                one, many;
   logic [IDX_W-1:0]    sel_idx;
   logic [CTR_W-1:0]    ctr;
   logic [PPN_W-1:0]    keep_pa;

   tlb_repl_ctr #(
      .N_ENTRIES(N_ENTRIES), .CTR_W(CTR_W), .ENABLE(HAS_REPL)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n), .step(acc_step), .bound(bound), .ctr(ctr)
   );

   assign use_asid = !(sv_mode && priv_mode);
   assign wr_ptr   = (HAS_REPL && wr_use_ctr) ? ctr[IDX_W-1:0] : wr_idx;

   always_comb begin
      wr_ent        = '0;
      wr_ent.valid  = wr_valid;
      wr_ent.shared = wr_shared;
      wr_ent.asid   = wr_asid;
      wr_ent.vpn    = wr_vpn;
      wr_ent.ppn    = wr_ppn;
      wr_ent.size   = wr_size;
      wr_ent.prot   = wr_prot;
      wr_ent.cache  = wr_cache;
      wr_ent.dirty  = wr_dirty;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_ENTRIES; i++) ent_q[i].valid <= 1'b0;
      end else if (inval_all) begin
         for (int i = 0; i < N_ENTRIES; i++) ent_q[i].valid <= 1'b0;
      end else if (wr_en) begin
         ent_q[wr_ptr] <= wr_ent;
      end
   end

   generate
      for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
         tlb_ent_cmp u_cmp (
            .ent(ent_q[g]), .va_pn(lk_vaddr[VA_W-1:PG_SHIFT]),
            .asid(lk_asid), .use_asid(use_asid), .match(match[g])
         );
      end
   endgenerate

   tlb_sel_or #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_sel (
      .match(match), .ents(ent_q), .one(one), .many(many),
      .idx(sel_idx), .sel(sel)
   );

   assign keep_pa = pg_keep(sel.size)[PPN_W-1:0];

   always_comb begin
      lk_hit   = one;
      lk_multi = many;
      lk_idx   = one ? sel_idx    : '0;
      lk_ppn   = one ? sel.ppn    : '0;
      lk_size  = one ? sel.size   : '0;
      lk_prot  = one ? sel.prot   : '0;
      lk_cache = one & sel.cache;
      lk_dirty = one & sel.dirty;
      lk_paddr = '0;
      if (one)
         lk_paddr = {(sel.ppn & keep_pa) | (lk_vaddr[PA_W-1:PG_SHIFT] & ~keep_pa),
                     lk_vaddr[PG_SHIFT-1:0]};
      repl_ctr = ctr;
   end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
   parameter int N_ENTRIES = 64,
   parameter int IDX_W     = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        inval_all,
   input logic        acc_step,
   input logic [5:0]  bound,
   input logic [31:0] lk_vaddr,
   input logic        lk_hit,
   input logic        lk_multi,
   input logic [28:0] lk_paddr,
   input logic [5:0]  repl_ctr
);
   AST_HIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_multi)); // R5
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[9:0] == lk_vaddr[9:0])); // R4
   AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      32'(repl_ctr) <= N_ENTRIES - 1); // R8
   AST_CTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      acc_step |=> (repl_ctr == 6'd0 || repl_ctr == $past(repl_ctr) + 6'd1)); // R7
   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_step |=> $stable(repl_ctr)); // R7
   AST_CTR_WRAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_step && bound != 6'd0 && repl_ctr >= bound) |=> repl_ctr == 6'd0); // R8
   AST_INVAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all |=> (!lk_hit && !lk_multi)); // R9
endmodule

bind tlb_assoc_lookup tlb_assoc_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .inval_all(inval_all), .acc_step(acc_step),
   .bound(bound), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_multi(lk_multi),
   .lk_paddr(lk_paddr), .repl_ctr(repl_ctr)
);

// File: tb/test_tlb_assoc_lookup.sv
module test_tlb_assoc_lookup;
   localparam int  N      = 64;
   localparam int  IW     = 6;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic inval_all = 0, wr_en = 0, wr_use_ctr = 0;
   logic [IW-1:0] wr_idx = '0;
   logic wr_valid = 0, wr_shared = 0;
   logic [7:0] wr_asid = '0;
   logic [21:0] wr_vpn = '0;
   logic [18:0] wr_ppn = '0;
   logic [1:0] wr_size = '0, wr_prot = '0;
   logic wr_cache = 0, wr_dirty = 0;
   logic [31:0] lk_vaddr = '0;
   logic [7:0] lk_asid = '0;
   logic sv_mode = 0, priv_mode = 0, acc_step = 0;
   logic [5:0] bound = '0;
   logic lk_hit, lk_multi, lk_cache, lk_dirty;
   logic [IW-1:0] lk_idx;
   logic [18:0] lk_ppn;
   logic [1:0] lk_size, lk_prot;
   logic [28:0] lk_paddr;
   logic [5:0] repl_ctr;

   int compared = 0, mismatched = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_assoc_lookup #(.N_ENTRIES(N)) i_tlb_assoc_lookup (.*);

   // behavioural reference model
   bit m_v [N]; bit m_sh [N]; int m_asid [N]; longint m_vpn [N]; longint m_ppn [N];
   int m_sz [N]; int m_pr [N]; bit m_c [N]; bit m_d [N];
   int m_ctr = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_v[i]) m_v[i] = 0;
         m_ctr = 0;
      end else begin
         if (inval_all) foreach (m_v[i]) m_v[i] = 0;
         else if (wr_en) begin
            automatic int s = wr_use_ctr ? m_ctr : int'(wr_idx);
            m_v[s] = wr_valid; m_sh[s] = wr_shared; m_asid[s] = wr_asid;
            m_vpn[s] = wr_vpn; m_ppn[s] = wr_ppn; m_sz[s] = wr_size;
            m_pr[s] = wr_prot; m_c[s] = wr_cache; m_d[s] = wr_dirty;
         end
         if (acc_step) begin
            m_ctr = m_ctr + 1;
            if ((bound != 0 && m_ctr > int'(bound)) || m_ctr > N - 1) m_ctr = 0;
         end
      end
   end

   function automatic longint pg_bytes(int code);
      case (code)
         0: return 1024;
         1: return 4096;
         2: return 65536;
         default: return 1048576;
      endcase
   endfunction

   task automatic chk(string what, longint act, longint exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      automatic int hits = 0, hi = 0;
      automatic bit ua = !(sv_mode && priv_mode);
      automatic longint va = longint'(lk_vaddr);
      automatic longint pa = 0;
      for (int i = 0; i < N; i++) begin
         automatic longint sz = pg_bytes(m_sz[i]);
         automatic longint base = (m_vpn[i] << 10) & ~(sz - 1);
         if (m_v[i] && (!ua || m_sh[i] || m_asid[i] == int'(lk_asid))
             && va >= base && va <= base + sz - 1) begin
            hits++; hi = i;
         end
      end
      chk("hit", lk_hit, hits == 1);
      chk("multi", lk_multi, hits > 1);
      chk("ctr", repl_ctr, m_ctr);
      if (hits == 1) begin
         automatic longint sz = pg_bytes(m_sz[hi]);
         pa = ((m_ppn[hi] << 10) & ~(sz - 1)) | (va & (sz - 1));
         chk("idx", lk_idx, hi); chk("ppn", lk_ppn, m_ppn[hi]);
         chk("size", lk_size, m_sz[hi]); chk("prot", lk_prot, m_pr[hi]);
         chk("cache", lk_cache, m_c[hi]); chk("dirty", lk_dirty, m_d[hi]);
         chk("paddr", lk_paddr, pa);
      end else begin
         chk("idx", lk_idx, 0); chk("ppn", lk_ppn, 0); chk("paddr", lk_paddr, 0);
         chk("cache", lk_cache, 0); chk("dirty", lk_dirty, 0);
      end
   endtask

   // inputs are set just after a falling edge; compare then wait a cycle
   task automatic tick();
      #1 compare();
      @(negedge clk);
   endtask

   task automatic put(int idx, bit v, bit sh, int asid, int vpn, int ppn, int sz, int pr, bit c, bit d);
      wr_en = 1; wr_use_ctr = 0; wr_idx = IW'(idx); wr_valid = v; wr_shared = sh;
      wr_asid = 8'(asid); wr_vpn = 22'(vpn); wr_ppn = 19'(ppn); wr_size = 2'(sz);
      wr_prot = 2'(pr); wr_cache = c; wr_dirty = d;
      tick();
      wr_en = 0;
   endtask

   task automatic look(int va);
      lk_vaddr = 32'(va);
      tick();
   endtask

   task automatic probe_page(int base, int bytes);
      look(base); look(base + bytes - 1); look(base + bytes); look(base - 1);
      look(base + bytes / 2 + 3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      cur_req = "R1"; tick();
      rst_n = 1; @(negedge clk);
      cur_req = "R1"; look(32'h0010_0000); look(0);

      // R10 explicit writes, R4 each page size, R6 fields
      cur_req = "R10";
      put(0, 1, 0, 5, 32'h0010_0000 >> 10, 19'h12345, 0, 1, 1, 0);
      put(1, 1, 0, 5, 32'h0020_0000 >> 10 | 2, 19'h0ABCD, 1, 2, 0, 1);
      put(2, 1, 0, 5, 32'h0040_0000 >> 10 | 7, 19'h7FFFF, 2, 3, 1, 1);
      put(3, 1, 0, 5, 32'h1000_0000 >> 10 | 32'h3FF, 19'h15555, 3, 0, 0, 1);
      lk_asid = 5;
      cur_req = "R4";
      probe_page(32'h0010_0000, 1024);
      probe_page(32'h0020_0000, 4096);
      probe_page(32'h0040_0000, 65536);
      probe_page(32'h1000_0000, 1048576);
      cur_req = "R6"; look(32'h0020_0ABC); look(32'h7000_0000);

      // R2 invalid entry is never matched
      cur_req = "R2";
      put(4, 0, 1, 5, 32'h0050_0000 >> 10, 19'h1, 0, 3, 1, 1);
      look(32'h0050_0000); look(32'h0050_0123);

      // R3 ASID and shared handling
      cur_req = "R3";
      put(5, 1, 1, 9, 32'h0060_0000 >> 10, 19'h22, 1, 1, 0, 0);
      lk_asid = 6; look(32'h0010_0010); look(32'h0060_0010);
      sv_mode = 1; priv_mode = 0; look(32'h0010_0010);
      sv_mode = 0; priv_mode = 1; look(32'h0010_0010);
      sv_mode = 1; priv_mode = 1; look(32'h0010_0010); look(32'h0020_0010);
      sv_mode = 0; priv_mode = 0; lk_asid = 5;

      // R5 overlapping entries
      cur_req = "R5";
      put(10, 1, 0, 5, 32'h1000_0400 >> 10, 19'h3, 0, 1, 1, 1);
      look(32'h1000_0400); look(32'h1000_07FF); look(32'h1000_0800);
      put(11, 1, 1, 0, 32'h0010_0000 >> 10, 19'h4, 0, 0, 0, 0);
      look(32'h0010_0000);

      // R7 / R8 counter behaviour
      cur_req = "R7"; acc_step = 1;
      for (int k = 0; k < 70; k++) tick();
      cur_req = "R8"; bound = 6'd5;
      for (int k = 0; k < 12; k++) tick();
      acc_step = 0; cur_req = "R7"; tick(); tick();
      cur_req = "R8"; bound = 6'd63; acc_step = 1;
      for (int k = 0; k < 66; k++) tick();
      acc_step = 0; bound = 6'd0;

      // R10 counter-directed write, with simultaneous step
      cur_req = "R10";
      wr_en = 1; wr_use_ctr = 1; wr_valid = 1; wr_shared = 0; wr_asid = 5;
      wr_vpn = 22'(32'h0300_0000 >> 10); wr_ppn = 19'h0F0F0; wr_size = 1;
      wr_prot = 2; wr_cache = 1; wr_dirty = 0; acc_step = 1;
      tick();
      wr_en = 0; acc_step = 0;
      look(32'h0300_0FFF); look(32'h0300_1000);

      // R9 invalidate overrides write
      cur_req = "R9";
      inval_all = 1; wr_en = 1; wr_use_ctr = 0; wr_idx = 20;
      wr_vpn = 22'(32'h0400_0000 >> 10); wr_size = 0;
      lk_vaddr = 32'h0400_0000;
      tick();
      inval_all = 0; wr_en = 0;
      look(32'h0400_0000); look(32'h0010_0000); look(32'h1000_0400);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule